// File: doc/BRIEF.md
# Bob and Weave Field Deinterlacer

This block turns a stream of interlaced video fields into progressive frames. Pixels enter on a valid/ready stream. The first pixel of each field carries a start-of-field flag, and the field parity is sampled together with that flag. Parity 0 marks the field that holds the top frame line; parity 1 marks the other field. The block stores the field in a two-bank on-chip buffer. It then emits a frame twice as tall as the field, line by line from top to bottom, on a valid/ready output stream.

The missing lines of each frame are rebuilt by one of three run-time methods:
- repeating a line of the current field;
- taking the rounded average of the current-field lines above and below;
- weaving in the lines of the field received just before.

A run-time pair selection makes the block emit one frame for every field, or one frame for every two fields. In pair mode, only fields whose parity matches a build-time anchor produce a frame. The other fields are only stored, so that weave can use them.

Top module: `field_deinterlacer`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: A field is LINE_PIX*FIELD_LINES accepted pixels, starting with a pixel that has in_sof_i=1. Pixels accepted while no field is open and in_sof_i=0 are discarded. in_ready_o is 0 whenever out_valid_o is 1.
- R3: Each emitted frame is 2*FIELD_LINES lines of LINE_PIX pixels, in top-to-bottom order. out_sof_o is 1 on the first pixel of the frame only, and out_eol_o is 1 on the last pixel of each line. After the last pixel, out_valid_o drops and in_ready_o rises.
- R4: Frame row r comes from current-field line r/2 when r mod 2 equals the field parity (0 = top-line field).
- R5: mode_i=0 (duplicate) fills a missing row with the current-field line directly above it. Where no line lies above, the row uses the line below. mode_i=3 behaves as mode 0.
- R6: mode_i=1 (interpolate) fills a missing row with the rounded average (a+b+1)>>1 of the lines above and below. The average is taken separately for each COMP_W-bit component. At the top or bottom edge, the single neighbour is copied.
- R7: mode_i=2 (weave) fills missing row r with line r/2 of the previously stored field. Until a first field has been stored, it falls back to mode 0.
- R8: With pair_i=1, only a field whose parity equals ANCHOR_F1 (default 0) produces a frame. Any other field is stored as the previous field and produces no output.
- R9: mode_i and pair_i are sampled only with the start-of-field pixel. Changing them later in the field has no effect on that field's frame.
- R10: in_sync_i has no effect on the output.
- R11: While out_valid_o=1 and out_ready_i=0, out_data_o, out_sof_o and out_eol_o hold their values.
- R12: A start-of-field pixel that arrives inside an open field discards the partial field and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Reconstruction method: 0 duplicate, 1 interpolate, 2 weave, 3 duplicate |
| pair_i | input | 1 | 1 = one frame per field pair |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_data_i | input | COMP_W*COMPS | Input pixel |
| in_sof_i | input | 1 | First pixel of a field |
| in_parity_i | input | 1 | Field parity, sampled with in_sof_i |
| in_sync_i | input | 2 | Synchronization marker bits, ignored |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | COMP_W*COMPS | Output pixel |
| out_sof_o | output | 1 | First pixel of a frame |
| out_eol_o | output | 1 | Last pixel of a line |

## Verification
Random field contents are sent with both parities under every mode. This separates the duplicate, interpolate and weave paths, and it shows up a wrong row placement or a wrong edge neighbour for each parity. Directed fields cover the following cases:
- weave before any field is stored, which exposes a missing fallback;
- a mode change inside a field, which exposes late sampling;
- stray pixels before a start flag, and a restart in mid-field;
- pair mode with both parities, which tells anchor fields from skipped fields.

Random output stalls check that the pixels hold under back-pressure.

// File: rtl/field_deint_pkg.sv
package field_deint_pkg;
  typedef enum logic [1:0] {
    MODE_DUP   = 2'd0,
    MODE_AVG   = 2'd1,
    MODE_WEAVE = 2'd2,
    MODE_RSVD  = 2'd3
  } deint_mode_e;

  typedef enum logic {
    ST_FILL = 1'b0,
    ST_EMIT = 1'b1
  } deint_state_e;
endpackage

// File: rtl/field_deint_store.sv
module field_deint_store #(
  parameter int DW    = 24,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          wbank_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rbank_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [2][DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wbank_i][waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[rbank_i][raddr_a_i];
  assign rdata_b_o = mem_q[rbank_i][raddr_b_i];
endmodule

// File: rtl/field_deint_linemap.sv
module field_deint_linemap
  import field_deint_pkg::*;
#(
  parameter int LINES = 4,
  localparam int LW   = $clog2(LINES),
  localparam int RW   = LW + 1
) (
  input  logic [RW-1:0] row_i,
  input  logic          parity_i,
  input  deint_mode_e   mode_i,
  input  logic          prev_ok_i,
  output logic [LW-1:0] line_a_o,
  output logic [LW-1:0] line_b_o,
  output logic          from_prev_o,
  output logic          blend_o
);
  logic [LW-1:0] half, above, below;
  logic [LW:0]   below_x;
  logic          above_ok, below_ok;

  assign half = row_i[RW-1:1];

  // Neighbouring current-field lines of a missing row
  always_comb begin
    below_x = {1'b0, half} + (LW+1)'(1);
    if (!parity_i) begin
      above    = half;
      above_ok = 1'b1;
      below    = below_x[LW-1:0];
      below_ok = below_x < (LW+1)'(LINES);
    end else begin
      above    = half - LW'(1);
      above_ok = half != '0;
      below    = half;
      below_ok = 1'b1;
    end
  end

  always_comb begin
    line_a_o    = half;
    line_b_o    = half;
    from_prev_o = 1'b0;
    blend_o     = 1'b0;
    if (row_i[0] != parity_i) begin
      if (mode_i == MODE_WEAVE && prev_ok_i) begin
        from_prev_o = 1'b1;
      end else begin
        line_a_o = above_ok ? above : below;
        line_b_o = line_a_o;
        if (mode_i == MODE_AVG) begin
          line_b_o = below_ok ? below : above;
          blend_o  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/field_deint_avg.sv
module field_deint_avg #(
  parameter int COMP_W = 8,
  parameter int COMPS  = 3,
  localparam int DW    = COMP_W * COMPS
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          blend_i,
  output logic [DW-1:0] pix_o
);
  for (genvar g = 0; g < COMPS; g++) begin : g_comp
    logic [COMP_W:0] sum;
    assign sum = {1'b0, a_i[g*COMP_W +: COMP_W]} + {1'b0, b_i[g*COMP_W +: COMP_W]} + (COMP_W+1)'(1);
    assign pix_o[g*COMP_W +: COMP_W] = blend_i ? sum[COMP_W:1] : a_i[g*COMP_W +: COMP_W];
  end
endmodule

// File: rtl/field_deinterlacer.sv
module field_deinterlacer
  import field_deint_pkg::*;
#(
  parameter int COMP_W      = 8,
  parameter int COMPS       = 3,
  parameter int LINE_PIX    = 8,
  parameter int FIELD_LINES = 4,
  parameter bit ANCHOR_F1   = 1'b0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                mode_i,
  input  logic                      pair_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [COMP_W*COMPS-1:0]   in_data_i,
  input  logic                      in_sof_i,
  input  logic                      in_parity_i,
  input  logic [1:0]                in_sync_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [COMP_W*COMPS-1:0]   out_data_o,
  output logic                      out_sof_o,
  output logic                      out_eol_o
);
  localparam int DW    = COMP_W * COMPS;
  localparam int DEPTH = LINE_PIX * FIELD_LINES;
  localparam int AW    = $clog2(DEPTH);
  localparam int CXW   = $clog2(LINE_PIX);
  localparam int LW    = $clog2(FIELD_LINES);
  localparam int RW    = LW + 1;

  deint_state_e state_q;
  deint_mode_e  fmode_q;
  logic          wbank_q, prev_ok_q, fpar_q, fpair_q, busy_q;
  logic [AW-1:0] waddr_q;
  logic [RW-1:0] row_q;
  logic [CXW-1:0] col_q;

  logic sync_unused;
  assign sync_unused = ^in_sync_i;

  // Fill side
  logic          acc, start, take, last, cur_par, cur_pair, emit_now;
  logic [AW-1:0] wr_addr;

  assign in_ready_o = state_q == ST_FILL;
  assign acc        = in_valid_i && in_ready_o;
  assign start      = acc && in_sof_i;
  assign take       = acc && (in_sof_i || busy_q);
  assign wr_addr    = start ? '0 : waddr_q;
  assign last       = take && wr_addr == AW'(DEPTH - 1);
  assign cur_par    = start ? in_parity_i : fpar_q;
  assign cur_pair   = start ? pair_i : fpair_q;
  assign emit_now   = !cur_pair || (cur_par == ANCHOR_F1);

  // Emit side
  logic          fire, col_end, row_end, from_prev, blend;
  logic [LW-1:0] line_a, line_b;
  logic [AW-1:0] raddr_a, raddr_b;
  logic [DW-1:0] rdata_a, rdata_b;

  assign out_valid_o = state_q == ST_EMIT;
  assign fire        = out_valid_o && out_ready_i;
  assign col_end     = col_q == CXW'(LINE_PIX - 1);
  assign row_end     = row_q == RW'(2 * FIELD_LINES - 1);
  assign out_sof_o   = row_q == '0 && col_q == '0;
  assign out_eol_o   = col_end;

  field_deint_linemap #(.LINES(FIELD_LINES)) u_map (
    .row_i      (row_q),
    .parity_i   (fpar_q),
    .mode_i     (fmode_q),
    .prev_ok_i  (prev_ok_q),
    .line_a_o   (line_a),
    .line_b_o   (line_b),
    .from_prev_o(from_prev),
    .blend_o    (blend)
  );

  assign raddr_a = AW'(line_a) * AW'(LINE_PIX) + AW'(col_q);
  assign raddr_b = AW'(line_b) * AW'(LINE_PIX) + AW'(col_q);

  field_deint_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .we_i     (take),
    .wbank_i  (wbank_q),
    .waddr_i  (wr_addr),
    .wdata_i  (in_data_i),
    .rbank_i  (from_prev ? ~wbank_q : wbank_q),
    .raddr_a_i(raddr_a),
    .raddr_b_i(raddr_b),
    .rdata_a_o(rdata_a),
    .rdata_b_o(rdata_b)
  );

  field_deint_avg #(.COMP_W(COMP_W), .COMPS(COMPS)) u_avg (
    .a_i    (rdata_a),
    .b_i    (rdata_b),
    .blend_i(blend),
    .pix_o  (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FILL;
      fmode_q   <= MODE_DUP;
      wbank_q   <= 1'b0;
      prev_ok_q <= 1'b0;
      fpar_q    <= 1'b0;
      fpair_q   <= 1'b0;
      busy_q    <= 1'b0;
      waddr_q   <= '0;
      row_q     <= '0;
      col_q     <= '0;
    end else if (state_q == ST_FILL) begin
      if (start) begin
        fpar_q  <= in_parity_i;
        fpair_q <= pair_i;
        fmode_q <= deint_mode_e'(mode_i);
      end
      if (take) begin
        waddr_q <= wr_addr + AW'(1);
        busy_q  <= 1'b1;
      end
      if (last) begin
        busy_q  <= 1'b0;
        waddr_q <= '0;
        if (emit_now) begin
          state_q <= ST_EMIT;
          row_q   <= '0;
          col_q   <= '0;
        end else begin
          wbank_q   <= ~wbank_q;
          prev_ok_q <= 1'b1;
        end
      end
    end else if (fire) begin
      if (col_end) begin
        col_q <= '0;
        if (row_end) begin
          row_q     <= '0;
          state_q   <= ST_FILL;
          wbank_q   <= ~wbank_q;
          prev_ok_q <= 1'b1;
        end else begin
          row_q <= row_q + RW'(1);
        end
      end else begin
        col_q <= col_q + CXW'(1);
      end
    end
  end
endmodule

// File: rtl/field_deinterlacer_chk.sv
module field_deinterlacer_chk #(
  parameter int LINE_PIX    = 8,
  parameter int FIELD_LINES = 4,
  parameter int DW          = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [DW-1:0] out_data_o,
  input logic          out_sof_o,
  input logic          out_eol_o
);
  int unsigned col_c, line_c;
  logic fire;
  assign fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_c  <= 0;
      line_c <= 0;
    end else if (fire) begin
      if (out_eol_o) begin
        col_c  <= 0;
        line_c <= (line_c == 2 * FIELD_LINES - 1) ? 0 : line_c + 1;
      end else begin
        col_c <= col_c + 1;
      end
    end
  end

  p_no_fill_while_emit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  p_hold_under_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_sof_o) && $stable(out_eol_o));

  p_frame_opens_sof_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_sof_o);

  p_eol_position_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_eol_o == (col_c == LINE_PIX - 1)));

  p_sof_position_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sof_o |-> col_c == 0 && line_c == 0);

  p_frame_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && out_eol_o && line_c == 2 * FIELD_LINES - 1 |=> !out_valid_o && in_ready_o);
endmodule

bind field_deinterlacer field_deinterlacer_chk #(
  .LINE_PIX(LINE_PIX), .FIELD_LINES(FIELD_LINES), .DW(COMP_W*COMPS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o),
  .out_sof_o  (out_sof_o),
  .out_eol_o  (out_eol_o)
);

// File: tb/field_deinterlacer_bench.sv
module field_deinterlacer_bench;
  localparam int LP = 8;
  localparam int FL = 4;
  localparam int NPIX = LP * FL;
  localparam bit ANCHOR = 1'b0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0, sync = 2'd0;
  logic pair = 1'b0, in_valid = 1'b0, in_sof = 1'b0, in_par = 1'b0, out_ready = 1'b0;
  logic [23:0] in_data = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [23:0] out_data;

  int n_chk = 0, n_bad = 0;
  logic [23:0] cur_f [FL][LP];
  logic [23:0] prev_f[FL][LP];
  logic [23:0] new_f [FL][LP];
  bit prev_ok = 0;

  always #5 clk = ~clk;

  field_deinterlacer u_field_deinterlacer (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pair_i(pair),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sof_i(in_sof), .in_parity_i(in_par), .in_sync_i(sync),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sof_o(out_sof), .out_eol_o(out_eol)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] avg_pix(input logic [23:0] a, input logic [23:0] b);
    logic [23:0] r;
    for (int k = 0; k < 3; k++) r[k*8 +: 8] = 8'((9'(a[k*8 +: 8]) + 9'(b[k*8 +: 8]) + 9'd1) >> 1);
    return r;
  endfunction

  function automatic logic [23:0] exp_pix(input int r, input int c, input int md, input int par);
    int ab, bl;
    bit ab_ok, bl_ok;
    if (r % 2 == par) return cur_f[r/2][c];
    if (md == 2 && prev_ok) return prev_f[r/2][c];
    ab = (par == 0) ? r/2 : r/2 - 1;
    bl = (par == 0) ? r/2 + 1 : r/2;
    ab_ok = ab >= 0;
    bl_ok = bl < FL;
    if (md == 1) return avg_pix(ab_ok ? cur_f[ab][c] : cur_f[bl][c], bl_ok ? cur_f[bl][c] : cur_f[ab][c]);
    return ab_ok ? cur_f[ab][c] : cur_f[bl][c];
  endfunction

  // Sends npix pixels; first carries sof when with_sof. Mid-field mode/pair scrambled when scramble.
  task automatic send_px(input int npix, input bit with_sof, input int par, input int md,
                         input int pr, input bit scramble, input int syn);
    for (int i = 0; i < npix; i++) begin
      bit done = 0;
      while (!done) begin
        @(negedge clk);
        in_valid = ($urandom % 4) != 0;
        in_data  = 24'($urandom);
        in_sof   = with_sof && i == 0;
        in_par   = (i == 0) ? 1'(par) : 1'($urandom);
        sync     = (syn >= 0) ? 2'(syn) : 2'($urandom);
        mode     = (scramble && i > 0) ? 2'($urandom) : 2'(md);
        pair     = (scramble && i > 0) ? 1'($urandom) : 1'(pr);
        if (in_valid && in_ready) begin
          new_f[i / LP][i % LP] = in_data;
          done = 1;
        end
      end
    end
    @(negedge clk);
    in_valid = 0;
    in_sof = 0;
  endtask

  task automatic recv_frame(input int md, input int par, input string req, input bit stall);
    int idx = 0, wait_c = 0;
    while (idx < 2 * NPIX && wait_c < 300) begin
      @(negedge clk);
      out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      if (out_valid) begin
        int r = idx / LP, c = idx % LP;
        logic [23:0] e = exp_pix(r, c, md, par);
        chk(out_data == e, req, 32'(out_data), 32'(e));
        chk(out_sof == (idx == 0) && out_eol == (c == LP - 1), "R3", {out_sof, out_eol}, {idx == 0, c == LP - 1});
        chk(!in_ready, "R2", 32'(in_ready), 0);
        if (out_ready) idx++;
        wait_c = 0;
      end else begin
        wait_c++;
      end
    end
    if (idx < 2 * NPIX) chk(0, "R3", idx, 2 * NPIX);
    @(negedge clk);
    out_ready = 0;
    chk(!out_valid && in_ready, "R3", {out_valid, in_ready}, 2'b01);
  endtask

  // Full field followed by model update and frame check (or check of silence in pair mode)
  task automatic field(input int par, input int md, input int pr, input string req,
                       input bit scramble, input int syn);
    send_px(NPIX, 1, par, md, pr, scramble, syn);
    if (pr == 0 || par == int'(ANCHOR)) begin
      cur_f = new_f;
      recv_frame(md, par, req, 1);
    end else begin
      chk(!out_valid && in_ready, "R8", {out_valid, in_ready}, 2'b01);
      repeat (3) @(negedge clk);
      chk(!out_valid, "R8", 32'(out_valid), 0);
    end
    prev_f = new_f;
    prev_ok = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(!out_valid && in_ready, "R1", {out_valid, in_ready}, 2'b01);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", {out_valid, in_ready}, 2'b01);

    field(0, 2, 0, "R7_fallback", 0, -1);
    field(1, 2, 0, "R7", 0, -1);
    field(0, 0, 0, "R4_R5", 0, -1);
    field(1, 0, 0, "R5_top_edge", 0, -1);
    field(1, 3, 0, "R5_mode3", 0, -1);
    field(0, 1, 0, "R6_bottom_edge", 0, -1);
    field(1, 1, 0, "R6_top_edge", 0, -1);
    field(0, 1, 0, "R9", 1, -1);
    field(1, 2, 0, "R10_sync3", 0, 3);
    field(1, 2, 0, "R10_sync0", 0, 0);

    send_px(5, 0, 1, 0, 0, 0, -1);
    chk(!out_valid && in_ready, "R2", {out_valid, in_ready}, 2'b01);
    field(1, 0, 0, "R2_stray", 0, -1);

    send_px(NPIX / 2 + 3, 1, 0, 1, 0, 0, -1);
    field(1, 1, 0, "R12", 0, -1);

    field(1, 2, 1, "R8", 0, -1);
    field(0, 2, 1, "R8_anchor", 0, -1);
    field(0, 1, 1, "R8_anchor", 0, -1);

    for (int n = 0; n < 24; n++)
      field(int'($urandom % 2), int'($urandom % 4), int'($urandom % 2), "R4_rand", 0, -1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule